// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine

This block computes a forward discrete Fourier transform over N complex fixed-point samples, where N is a power of two. A host writes the samples one per cycle through a load port, giving each sample's position in time. The engine stores every sample at the bit-reversed form of that position, so the working memory already holds the decimated-in-time ordering when the transform begins.

A start pulse runs log2(N) passes of two-point butterflies over the same storage. Each pass merges pairs of half-length spectra into spectra of twice the length. A butterfly takes one complex product of its odd input with a twiddle factor from a built-in table. It adds that product to the even input to make one output and subtracts it to make the other. Every result is halved, so the whole transform is scaled by 1/N and stays in range.

When the last butterfly has been written back, a one-cycle done flag rises. The spectrum can then be read in natural bin order through an asynchronous read port. The work takes N/2·log2(N) cycles, which is of order N log N rather than N².

Top module: `fft_r2dit`

## Requirements
- R1: After reset, busy and done are low and every location read through the read port returns zero in both real and imaginary parts.
- R2: While idle, a sample loaded with ld_valid at index i is stored at the location whose LG address bits are those of i in reverse order (for N=16, index 1 lands at location 8 and index 3 at location 12), and can be read back there before a transform starts.
- R3: A start pulse while idle raises busy on the next cycle. Busy stays high for exactly N/2·log2(N) cycles (32 for N=16). Done is then high for exactly one cycle, in the cycle busy falls.
- R4: For a real impulse of amplitude A at time 0, every output bin equals A/N in the real part and 0 in the imaginary part, within 4 LSB.
- R5: For a real cosine of amplitude A at bin m, bins m and N−m equal A/2 in the real part and every other bin is zero, within 4 LSB.
- R6: For an impulse of amplitude A at time 1, bin k equals (A/N)·(cos(2πk/N) − j·sin(2πk/N)) within 4 LSB. Twiddles are Q15 cosine and negative sine over N/2 entries.
- R7: While busy, ld_valid and start have no effect: the result and the cycle at which done rises are the same as without them.
- R8: Each butterfly output is the halved sum and the halved difference of the even input and one shared twiddled product, saturated to W bits, so a full transform equals the true DFT scaled by 1/N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Write one sample this cycle (idle only) |
| ld_idx | input | LG | Time index of the sample in natural order |
| ld_re | input | W | Sample real part, signed |
| ld_im | input | W | Sample imaginary part, signed |
| start | input | 1 | Begin the transform (idle only) |
| busy | output | 1 | Butterflies in progress |
| done | output | 1 | One-cycle pulse when the spectrum is complete |
| rd_idx | input | LG | Bin to read, natural order |
| rd_re | output | W | Real part at rd_idx |
| rd_im | output | W | Imaginary part at rd_idx |

## Verification
The assertions assume that loads and start pulses only matter while the engine is idle. They also assume that reset is held for at least one clock edge before any traffic. The bench loads all N samples before every start, so no stale data from an earlier run reaches a result. Input amplitudes stay at or below 2^13 so that no stage saturates and the tolerance of a few LSB covers only truncation. The one test that drives loads and starts during a run checks that these inputs leave no mark on the outputs.

// File: rtl/fft_r2dit.sv
`timescale 1ns/1ps
module fft_r2dit #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int TW = 16,
  localparam int LG = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  input  logic [LG-1:0]       ld_idx,
  input  logic signed [W-1:0] ld_re,
  input  logic signed [W-1:0] ld_im,
  input  logic                start,
  output logic                busy,
  output logic                done,
  input  logic [LG-1:0]       rd_idx,
  output logic signed [W-1:0] rd_re,
  output logic signed [W-1:0] rd_im
);
  localparam int HALF = N / 2;
  localparam int PW   = W + TW + 1;
  localparam int SW   = W + 3;
  localparam int QMAX = (1 << (TW - 1)) - 1;

  function automatic int q15_trig(input int k, input bit is_sin);
    real ang, term, acc, v;
    ang  = 2.0 * 3.14159265358979323846 * k / N;
    term = is_sin ? ang : 1.0;
    acc  = term;
    for (int i = 1; i < 24; i++) begin
      term = -term * ang * ang / ((is_sin ? 2*i : 2*i-1) * (is_sin ? 2*i+1 : 2*i));
      acc  = acc + term;
    end
    v = acc * (QMAX + 1);
    if (v >= 0.0) q15_trig = $rtoi(v + 0.5);
    else          q15_trig = -$rtoi(-v + 0.5);
    if (q15_trig > QMAX) q15_trig = QMAX;
    if (q15_trig < -QMAX - 1) q15_trig = -QMAX - 1;
  endfunction

  function automatic logic [LG-1:0] brev(input logic [LG-1:0] v);
    for (int i = 0; i < LG; i++) brev[i] = v[LG-1-i];
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [SW-1:0] v);
    if (v > $signed(SW'((1 << (W-1)) - 1)))      sat = {1'b0, {(W-1){1'b1}}};
    else if (v < -$signed(SW'(1 << (W-1))))      sat = {1'b1, {(W-1){1'b0}}};
    else                                         sat = v[W-1:0];
  endfunction

  logic signed [TW-1:0] tw_re [HALF];
  logic signed [TW-1:0] tw_im [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_tw
    localparam int CV = q15_trig(k, 1'b0);
    localparam int SV = -q15_trig(k, 1'b1);
    assign tw_re[k] = CV[TW-1:0];
    assign tw_im[k] = SV[TW-1:0];
  end

  logic signed [W-1:0] mem_re [N];
  logic signed [W-1:0] mem_im [N];
  logic [LG-1:0] stg;
  logic [LG-1:0] bf;

  logic [LG-1:0] kk, top, bot, widx, mask;
  assign mask = LG'((1 << stg) - 1);
  assign kk   = bf & mask;
  assign top  = ((bf >> stg) << (stg + 1)) | kk;
  assign bot  = top | LG'(1 << stg);
  assign widx = kk << (LG - 1 - stg);

  logic signed [W-1:0]  ar, ai, br, bi;
  logic signed [TW-1:0] wr, wi;
  assign ar = mem_re[top];
  assign ai = mem_im[top];
  assign br = mem_re[bot];
  assign bi = mem_im[bot];
  assign wr = tw_re[widx[LG-2:0]];
  assign wi = tw_im[widx[LG-2:0]];

  logic signed [PW-1:0] pr, pi;
  assign pr = PW'(br * wr) - PW'(bi * wi);
  assign pi = PW'(br * wi) + PW'(bi * wr);

  logic signed [SW-1:0] tr, ti, s0r, s0i, s1r, s1i;
  assign tr  = SW'(pr >>> (TW - 1));
  assign ti  = SW'(pi >>> (TW - 1));
  assign s0r = (SW'(ar) + tr) >>> 1;
  assign s0i = (SW'(ai) + ti) >>> 1;
  assign s1r = (SW'(ar) - tr) >>> 1;
  assign s1i = (SW'(ai) - ti) >>> 1;

  assign rd_re = mem_re[rd_idx];
  assign rd_im = mem_im[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      stg  <= '0;
      bf   <= '0;
      for (int i = 0; i < N; i++) begin
        mem_re[i] <= '0;
        mem_im[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ld_valid) begin
          mem_re[brev(ld_idx)] <= ld_re;
          mem_im[brev(ld_idx)] <= ld_im;
        end
        if (start) begin
          busy <= 1'b1;
          stg  <= '0;
          bf   <= '0;
        end
      end else begin
        mem_re[top] <= sat(s0r);
        mem_im[top] <= sat(s0i);
        mem_re[bot] <= sat(s1r);
        mem_im[bot] <= sat(s1i);
        if (bf == LG'(HALF - 1)) begin
          bf <= '0;
          if (stg == LG'(LG - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stg <= stg + 1'b1;
          end
        end else begin
          bf <= bf + 1'b1;
        end
      end
    end
  end
endmodule

module fft_r2dit_chk #(
  parameter int N  = 16,
  parameter int W  = 16,
  localparam int LG = $clog2(N)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_valid,
  input logic [LG-1:0]       ld_idx,
  input logic signed [W-1:0] ld_re,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic signed [W-1:0] mem_re [N]
);
  function automatic logic [LG-1:0] rev(input logic [LG-1:0] v);
    for (int i = 0; i < LG; i++) rev[i] = v[LG-1-i];
  endfunction

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R3
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R2
  load_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ld_valid) |=> (mem_re[rev($past(ld_idx))] == $past(ld_re)));

  // R7
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

bind fft_r2dit fft_r2dit_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
  .ld_re(ld_re), .start(start), .busy(busy), .done(done), .mem_re(mem_re)
);

// File: tb/fft_r2dit_tb_top.sv
`timescale 1ns/1ps
module fft_r2dit_tb_top;
  localparam int N  = 16;
  localparam int W  = 16;
  localparam int LG = 4;
  localparam int RUN_CYC = N / 2 * LG;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [LG-1:0] ld_idx = '0;
  logic signed [W-1:0] ld_re = '0, ld_im = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [LG-1:0] rd_idx = '0;
  logic signed [W-1:0] rd_re, rd_im;

  int n_chk = 0;
  int n_bad = 0;
  int xr [N];
  int xi [N];

  always #4 clk = ~clk;

  fft_r2dit #(.N(N), .W(W), .TW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_re(ld_re), .ld_im(ld_im), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im)
  );

  task automatic check(input string req, input string what, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_all();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_idx = LG'(n); ld_re = W'(xr[n]); ld_im = W'(xi[n]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_fft(input string req, input bit disturb);
    int cyc;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3", "busy after start", int'(busy), 1, 0);
    cyc = 1;
    while (!done && cyc < 200) begin
      if (disturb && cyc == 5) begin
        ld_valid = 1'b1; ld_idx = '0; ld_re = 16'sd12000; ld_im = -16'sd9000; start = 1'b1;
      end else begin
        ld_valid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    ld_valid = 1'b0; start = 1'b0;
    check(req, "cycles start to done", cyc, RUN_CYC + 1, 0);
    check("R3", "busy low with done", int'(busy), 0, 0);
    @(negedge clk);
    check("R3", "done one cycle", int'(done), 0, 0);
  endtask

  task automatic check_spectrum(input string req);
    real er, ei, th;
    for (int k = 0; k < N; k++) begin
      er = 0.0; ei = 0.0;
      for (int n = 0; n < N; n++) begin
        th = 2.0 * PI * k * n / N;
        er = er + xr[n] * $cos(th) + xi[n] * $sin(th);
        ei = ei + xi[n] * $cos(th) - xr[n] * $sin(th);
      end
      rd_idx = LG'(k);
      #1;
      check(req, $sformatf("bin %0d re", k), int'(rd_re), $rtoi(er / N + (er >= 0 ? 0.5 : -0.5)), 4);
      check(req, $sformatf("bin %0d im", k), int'(rd_im), $rtoi(ei / N + (ei >= 0 ? 0.5 : -0.5)), 4);
    end
  endtask

  task automatic t_reset();
    check("R1", "busy", int'(busy), 0, 0);
    check("R1", "done", int'(done), 0, 0);
    for (int k = 0; k < N; k += 5) begin
      rd_idx = LG'(k);
      #1;
      check("R1", "mem re", int'(rd_re), 0, 0);
      check("R1", "mem im", int'(rd_im), 0, 0);
    end
  endtask

  task automatic t_bitrev();
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = 4'd1; ld_re = 16'sd111; ld_im = -16'sd222;
    @(negedge clk);
    ld_idx = 4'd3; ld_re = 16'sd333; ld_im = 16'sd44;
    @(negedge clk);
    ld_valid = 1'b0;
    rd_idx = 4'd8;
    #1;
    check("R2", "idx1 at 8 re", int'(rd_re), 111, 0);
    check("R2", "idx1 at 8 im", int'(rd_im), -222, 0);
    rd_idx = 4'd12;
    #1;
    check("R2", "idx3 at 12 re", int'(rd_re), 333, 0);
    rd_idx = 4'd1;
    #1;
    check("R2", "loc 1 untouched", int'(rd_re), 0, 0);
  endtask

  task automatic t_impulse();
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 8000;
    load_all();
    run_fft("R3", 1'b0);
    check_spectrum("R4");
  endtask

  task automatic t_shifted();
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[1] = 8192;
    load_all();
    run_fft("R3", 1'b0);
    check_spectrum("R6");
  endtask

  task automatic t_tone();
    for (int n = 0; n < N; n++) begin
      xr[n] = $rtoi(8192.0 * $cos(2.0 * PI * 3 * n / N) + 8192.5) - 8192;
      xi[n] = 0;
    end
    load_all();
    run_fft("R3", 1'b0);
    check_spectrum("R5");
  endtask

  task automatic t_complex();
    for (int n = 0; n < N; n++) begin
      xr[n] = (n * 977) % 4001 - 2000;
      xi[n] = (n * 613) % 3001 - 1500;
    end
    load_all();
    run_fft("R3", 1'b0);
    check_spectrum("R8");
  endtask

  task automatic t_busy_ignore();
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 4096; xi[0] = -2048;
    load_all();
    run_fft("R7", 1'b1);
    check_spectrum("R7");
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bitrev();
    t_impulse();
    t_shifted();
    t_tone();
    t_complex();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule